// File: doc/BRIEF.md
# Card Clock and Soft-Reset Controller

This unit sits in a memory-card host next to the command engine. It makes the card clock from a fixed source clock, divided by a power of two that software picks, and it starts and stops that clock without glitches. Software controls it through a 16-bit strobe word and a 3-bit divider exponent. Each strobe bit is a write-one pulse: start the clock, stop the clock, launch an operation, or run a soft reset. Two status outputs report whether the card clock is still active and whether a soft reset is in progress. Software polls them after a stop or a reset.

The card clock is the source clock gated by an enable. The enable only changes while the source clock is low. Each divided period therefore holds exactly one high pulse, half a source period wide. When software launches an operation, the command engine receives a one-cycle pulse once the clock is confirmed running.

Top module: `card_clk_ctrl`

## Requirements
- R1: Strobe bit positions are fixed: bit 0 stops the clock, bit 1 starts it, bit 2 requests an operation and bit 3 requests a soft reset. Bits 15..4 are ignored, and a strobe write with none of bits 3..0 set changes nothing.
- R2: With divider exponent n (0 to 7), rising edges of the card clock are 2^n source cycles apart. Each card pulse is high only during a source high phase.
- R3: A new exponent takes effect only at the boundary of a divided period. Every interval between card edges equals either the old period or the new period, and the intervals after the change equal the new period.
- R4: The clock-active status reads 1 from the cycle after a start. After a stop it reads 0 only once the last card pulse has ended, and no card edge occurs while it reads 0.
- R5: A write that sets both stop and start leaves the clock stopped.
- R6: An operation request is emitted as a pulse on the operation output that lasts exactly one source cycle. When it is written together with start while the clock is stopped, the pulse appears in the second cycle after the write is sampled.
- R7: An operation requested while the clock is stopped is held and issued after a later start. A stop discards a held request.
- R8: A soft reset raises the resetting status in the cycle after the write, for exactly RST_CYCLES (16) source cycles. It stops the clock and sets the divider exponent to 0.
- R9: While a soft reset is in progress, strobe writes and divider writes are ignored.
- R10: After the hardware reset the card clock is idle, both status outputs read 0 and no operation pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| stb_wr_i | input | 1 | Strobe word write enable |
| stb_data_i | input | 16 | Strobe word (bit 0 stop, 1 start, 2 operation, 3 soft reset) |
| div_wr_i | input | 1 | Divider write enable |
| div_data_i | input | 3 | Divider exponent n, card clock = source / 2^n |
| card_clk_o | output | 1 | Gated, divided card clock |
| clk_on_o | output | 1 | Card clock active status |
| resetting_o | output | 1 | Soft reset in progress |
| op_start_o | output | 1 | One-cycle operation launch to the command engine |

## Verification
The bench builds the block with its default parameters: a 16-bit strobe word, a 3-bit exponent and a 16-cycle soft reset. With these values the whole divider range is reachable, from source/1 up to source/128, and a 128-cycle period still fits in short runs. The reset window is short enough to land two ignored writes inside it and to count its length exactly. The bench measures edge-to-edge card periods and checks them against 2^n source periods, including across a switch from a slow to a fast exponent.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
    // Strobe bit positions decoded by the sequencer (software-visible order)
    localparam int unsigned BIT_STOP  = 0;
    localparam int unsigned BIT_START = 1;
    localparam int unsigned BIT_OP    = 2;
    localparam int unsigned BIT_RST   = 3;
    localparam int unsigned BIT_USED  = 4;
endpackage

// File: rtl/ccc_seq.sv
module ccc_seq #(
    parameter int unsigned STB_W      = 16,
    parameter int unsigned DIV_W      = 3,
    parameter int unsigned RST_CYCLES = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stb_wr_i,
    input  logic [STB_W-1:0] stb_data_i,
    input  logic             div_wr_i,
    input  logic [DIV_W-1:0] div_data_i,
    output logic             run_o,
    output logic             op_o,
    output logic             resetting_o,
    output logic [DIV_W-1:0] n_req_o
);
    import ccc_pkg::*;

    localparam int unsigned RC_W = $clog2(RST_CYCLES + 1);
    localparam logic [RC_W-1:0] RC_ONE  = RC_W'(1);
    localparam logic [RC_W-1:0] RC_LOAD = RC_W'(RST_CYCLES);

    typedef struct packed {
        logic             run;
        logic             pend;
        logic             op;
        logic [RC_W-1:0]  rst_cnt;
        logic [DIV_W-1:0] n_req;
    } seq_t;

    seq_t s_d, s_q;
    logic busy;

    logic unused_hi_bits;
    assign unused_hi_bits = ^stb_data_i[STB_W-1:BIT_USED];

    always_comb begin
        s_d    = s_q;
        s_d.op = 1'b0;
        busy   = (s_q.rst_cnt != '0);
        if (busy) begin
            s_d.rst_cnt = s_q.rst_cnt - RC_ONE;
            s_d.run     = 1'b0;
            s_d.pend    = 1'b0;
            s_d.n_req   = '0;
        end else if (stb_wr_i && stb_data_i[BIT_RST]) begin
            s_d.rst_cnt = RC_LOAD;
            s_d.run     = 1'b0;
            s_d.pend    = 1'b0;
            s_d.n_req   = '0;
        end else begin
            // Issue a held request once the clock is already running
            if (s_q.pend && s_q.run) begin
                s_d.op   = 1'b1;
                s_d.pend = 1'b0;
            end
            if (div_wr_i) begin
                s_d.n_req = div_data_i;
            end
            if (stb_wr_i) begin
                if (stb_data_i[BIT_STOP]) begin
                    s_d.run  = 1'b0;
                    s_d.pend = 1'b0;
                end else begin
                    if (stb_data_i[BIT_START]) s_d.run  = 1'b1;
                    if (stb_data_i[BIT_OP])    s_d.pend = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign run_o       = s_q.run;
    assign op_o        = s_q.op;
    assign resetting_o = (s_q.rst_cnt != '0);
    assign n_req_o     = s_q.n_req;

    AST_OP_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.op |-> $past(s_q.run)); // R6
    AST_RST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resetting_o |-> (!s_q.run && !s_q.op && s_q.n_req == '0)); // R8
    AST_RST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.rst_cnt == RC_ONE) |=> !resetting_o); // R8
endmodule

// File: rtl/ccc_divider.sv
module ccc_divider #(
    parameter int unsigned DIV_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic [DIV_W-1:0] n_req_i,
    output logic             en_pos_o
);
    localparam int unsigned CNT_W = (1 << DIV_W) - 1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] n_eff;
        logic             en_pos;
    } div_t;

    div_t d_d, d_q;
    logic [CNT_W-1:0] limit;
    logic             tick;

    always_comb begin
        // 2^n - 1 in CNT_W bits; the top exponent wraps to all ones
        limit      = (ONE << d_q.n_eff) - ONE;
        tick       = (d_q.cnt == limit);
        d_d        = d_q;
        d_d.en_pos = run_i & tick;
        if (clear_i) begin
            d_d.cnt   = '0;
            d_d.n_eff = '0;
        end else if (tick) begin
            d_d.cnt   = '0;
            d_d.n_eff = n_req_i;
        end else begin
            d_d.cnt   = d_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) d_q <= '0;
        else         d_q <= d_d;
    end

    assign en_pos_o = d_q.en_pos;

    AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick && !clear_i) |=> $stable(d_q.n_eff)); // R3
    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        d_q.cnt <= limit); // R2
endmodule

// File: rtl/ccc_gate.sv
module ccc_gate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic en_low_o,
    output logic card_clk_o
);
    logic en_low_d, en_low_q;

    assign en_low_d = en_i;

    // Enable moves only while the source clock is low
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_low_q <= 1'b0;
        else         en_low_q <= en_low_d;
    end

    assign en_low_o   = en_low_q;
    assign card_clk_o = clk_i & en_low_q;
endmodule

// File: rtl/card_clk_ctrl.sv
module card_clk_ctrl #(
    parameter int unsigned STB_W      = 16,
    parameter int unsigned DIV_W      = 3,
    parameter int unsigned RST_CYCLES = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stb_wr_i,
    input  logic [STB_W-1:0] stb_data_i,
    input  logic             div_wr_i,
    input  logic [DIV_W-1:0] div_data_i,
    output logic             card_clk_o,
    output logic             clk_on_o,
    output logic             resetting_o,
    output logic             op_start_o
);
    logic             run;
    logic             en_pos;
    logic             en_low;
    logic [DIV_W-1:0] n_req;

    ccc_seq #(
        .STB_W      (STB_W),
        .DIV_W      (DIV_W),
        .RST_CYCLES (RST_CYCLES)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .stb_wr_i    (stb_wr_i),
        .stb_data_i  (stb_data_i),
        .div_wr_i    (div_wr_i),
        .div_data_i  (div_data_i),
        .run_o       (run),
        .op_o        (op_start_o),
        .resetting_o (resetting_o),
        .n_req_o     (n_req)
    );

    ccc_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run),
        .clear_i  (resetting_o),
        .n_req_i  (n_req),
        .en_pos_o (en_pos)
    );

    ccc_gate u_gate (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (en_pos),
        .en_low_o   (en_low),
        .card_clk_o (card_clk_o)
    );

    // Active while enabled or while a granted pulse is still in flight
    assign clk_on_o = run | en_pos | en_low;

    AST_STOP_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run && !en_pos) |=> !en_pos); // R4
endmodule

// File: tb/card_clk_ctrl_tb.sv
`timescale 1ns/1ps
module card_clk_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stb_wr = 1'b0;
    logic [15:0] stb_data = '0;
    logic        div_wr = 1'b0;
    logic [2:0]  div_data = '0;
    logic        card_clk, clk_on, resetting, op_start;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    int ops    = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    card_clk_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .stb_wr_i(stb_wr), .stb_data_i(stb_data),
        .div_wr_i(div_wr), .div_data_i(div_data), .card_clk_o(card_clk),
        .clk_on_o(clk_on), .resetting_o(resetting), .op_start_o(op_start)
    );

    always @(posedge card_clk) edges++;
    always @(negedge clk) if (op_start) ops++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_stb(input logic [15:0] v);
        @(negedge clk); stb_wr = 1'b1; stb_data = v;
        @(negedge clk); stb_wr = 1'b0; stb_data = '0;
    endtask

    task automatic wr_div(input logic [2:0] v);
        @(negedge clk); div_wr = 1'b1; div_data = v;
        @(negedge clk); div_wr = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_off();
        for (int i = 0; i < 400 && clk_on; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic period_ns(output int p);
        realtime t0;
        @(posedge card_clk); t0 = $realtime;
        @(posedge card_clk); p = int'($realtime - t0);
    endtask

    task automatic t_reset_state();
        cycles(4);
        chk(!clk_on && !resetting && !op_start, "R10 idle outputs",
            {clk_on, resetting, op_start}, 0);
        chk(edges == 0, "R10 no card edges", edges, 0);
    endtask

    task automatic t_periods();
        int p;
        int e[4] = '{0, 1, 3, 7};
        wr_stb(16'h0002);
        chk(clk_on, "R4 active after start", clk_on, 1);
        foreach (e[k]) begin
            wr_div(3'(e[k]));
            cycles(300);
            period_ns(p);
            chk(p == 5 * (1 << e[k]), "R2 card period", p, 5 * (1 << e[k]));
        end
    endtask

    task automatic t_div_switch();
        int p;
        bit ok = 1;
        wr_div(3'd4);
        cycles(100);
        wr_div(3'd1);
        for (int i = 0; i < 4; i++) begin
            period_ns(p);
            if (p != 80 && p != 10) ok = 0;
        end
        chk(ok, "R3 intervals old or new only", p, 10);
        chk(p == 10, "R3 new period in force", p, 10);
    endtask

    task automatic t_ignored_bits();
        int o0 = ops;
        wr_stb(16'hFFF0);
        cycles(10);
        chk(clk_on && !resetting, "R1 high bits ignored", {clk_on, resetting}, 2);
        chk(ops == o0, "R1 no op from high bits", ops - o0, 0);
    endtask

    task automatic t_stop_drain();
        int e0, e1;
        wr_div(3'd0);
        cycles(10);
        e0 = edges;
        wr_stb(16'h0001);
        wait_off();
        e1 = edges;
        chk(!clk_on, "R4 status falls after stop", clk_on, 0);
        chk(e1 - e0 <= 3, "R4 edges after stop bounded", e1 - e0, 3);
        cycles(300);
        chk(edges == e1, "R4 no edge while inactive", edges - e1, 0);
    endtask

    task automatic t_stop_prio();
        wr_stb(16'h0003);
        cycles(20);
        chk(!clk_on, "R5 stop wins over start", clk_on, 0);
    endtask

    task automatic t_op_timing();
        int o0 = ops;
        @(negedge clk); stb_wr = 1'b1; stb_data = 16'h0006;
        @(posedge clk); #1; stb_wr = 1'b0; stb_data = '0;
        chk(!op_start, "R6 no pulse in first cycle", op_start, 0);
        chk(clk_on, "R6 clock active", clk_on, 1);
        @(posedge clk); #1;
        chk(op_start, "R6 pulse in second cycle", op_start, 1);
        @(posedge clk); #1;
        chk(!op_start, "R6 pulse one cycle wide", op_start, 0);
        cycles(10);
        chk(ops - o0 == 1, "R6 single pulse", ops - o0, 1);
    endtask

    task automatic t_pending();
        int o0;
        wr_stb(16'h0001);
        wait_off();
        o0 = ops;
        wr_stb(16'h0004);
        cycles(20);
        chk(ops == o0, "R7 held while stopped", ops - o0, 0);
        wr_stb(16'h0002);
        cycles(5);
        chk(ops - o0 == 1, "R7 issued after start", ops - o0, 1);
        wr_stb(16'h0001);
        wait_off();
        o0 = ops;
        wr_stb(16'h0004);
        wr_stb(16'h0001);
        wr_stb(16'h0002);
        cycles(10);
        chk(ops == o0, "R7 stop discards request", ops - o0, 0);
    endtask

    task automatic t_soft_reset();
        int n = 0;
        int p;
        wr_div(3'd3);
        cycles(20);
        @(negedge clk); stb_wr = 1'b1; stb_data = 16'h0008;
        @(posedge clk); #1; stb_wr = 1'b0; stb_data = '0;
        while (resetting && n < 100) begin
            n++;
            @(posedge clk); #1;
        end
        chk(n == 16, "R8 resetting length", n, 16);
        wait_off();
        chk(!clk_on, "R8 clock stopped by reset", clk_on, 0);
        wr_stb(16'h0008);
        wr_stb(16'h0002);
        wr_div(3'd5);
        chk(resetting, "R9 writes landed inside reset", resetting, 1);
        cycles(20);
        chk(!resetting, "R8 reset cleared itself", resetting, 0);
        chk(!clk_on, "R9 start ignored during reset", clk_on, 0);
        wr_stb(16'h0002);
        cycles(10);
        period_ns(p);
        chk(p == 5, "R8 R9 divider zero after reset", p, 5);
    endtask

    initial begin
        #500000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset_state();
        t_periods();
        t_div_switch();
        t_ignored_bits();
        t_stop_drain();
        t_stop_prio();
        t_op_timing();
        t_pending();
        t_soft_reset();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule